// File: doc/BRIEF.md
# Charge Setpoint Limiter

This block turns the charging voltage and charging current words written by a host into the setpoints an analog charger loop may use. Both words arrive in plain units (millivolts and milliamps). Two resistor-sense comparator banks report a thermometer code each. The codes choose a hardware voltage ceiling and a hardware current ceiling that no host value can exceed. The voltage path rounds down to a 16 mV step, clamps at the selected ceiling and removes the fixed 1104 mV reference offset. A request below that reference gives a zero setpoint. The current path rounds down to the step size of the selected range and clamps at its full-scale value. A flag reports each clamp.

A single-cycle `load` strobe captures both words together with the current comparator codes. The registered outputs change on the clock edge that samples `load` and then hold until the next strobe. There is no back-pressure: the block accepts every strobe, so a host that pulses `load` on consecutive cycles gets one result per cycle. Changes on any input without a strobe do not reach the outputs.

Top module: `chg_limit_clamp`

## Requirements
- R1: While `rst_n` is low, and after reset until the first strobe, `v_set`, `i_set`, `i_fullscale`, `v_over` and `i_over` are all zero.
- R2: The current sense code `i_sense` (bit 0 is the lowest comparator) selects the current full-scale: 3'b000 gives 1023 mA, 3'b001 gives 2046, 3'b011 gives 3068 and 3'b111 gives 4092. The value is shown on `i_fullscale`.
- R3: The voltage sense code `v_sense` (bit 0 is the lowest comparator) selects the voltage ceiling: 4'b0000 gives 4240 mV, 4'b0001 gives 4304, 4'b0011 gives 4432, 4'b0111 gives 4512 and 4'b1111 gives 5504.
- R4: A sense code that is not a thermometer pattern (a set bit above a clear bit) selects the lowest setting of that bank: 4240 mV or 1023 mA.
- R5: For 1104 <= `v_req` <= ceiling, `v_set` = floor(`v_req`/16)*16 - 1104 and `v_over` = 0, so `v_set` is always a multiple of 16.
- R6: For `v_req` > ceiling, `v_set` = ceiling - 1104 and `v_over` = 1.
- R7: For `v_req` < 1104, `v_set` = 0 and `v_over` = 0.
- R8: For `i_req` <= full-scale, `i_set` is `i_req` rounded down to the step of the range (1, 2, 4 and 4 mA for codes 000, 001, 011 and 111), with `i_over` = 0.
- R9: For `i_req` > full-scale, `i_set` = full-scale and `i_over` = 1.
- R10: All outputs take their new values on the clock edge that samples `load` high. They hold while `load` is low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Strobe that captures requests and sense codes |
| v_req | input | 16 | Requested charging voltage, mV |
| i_req | input | 16 | Requested charging current, mA |
| v_sense | input | 4 | Voltage ceiling comparator thermometer code |
| i_sense | input | 3 | Current ceiling comparator thermometer code |
| v_set | output | 16 | Clamped voltage setpoint with the reference removed, mV |
| i_set | output | 16 | Clamped current setpoint, mA |
| i_fullscale | output | 16 | Selected current full-scale, mA |
| v_over | output | 1 | Voltage request was clamped |
| i_over | output | 1 | Current request was clamped |

## Verification
The hardest situations to reach are at the edges of the clamps and steps. These are requests exactly at a ceiling, one above it, and within one 16 mV step above it. They also include the reference value itself, where the result must stay zero, and the first step above it. The stimulus reaches each one by pairing every sense code with requests chosen at those exact values. It also drives non-thermometer codes into both banks. Then, with `load` low, it changes every input for several cycles to confirm that the outputs hold.

// File: rtl/chg_pkg.sv
package chg_pkg;
  localparam int VREF_MV     = 1104;
  localparam int VSTEP_SHIFT = 4;
  localparam int VCEIL_MIN   = 4240;
  localparam int ICEIL_MIN   = 1023;

  function automatic int vceil_mv(input int level);
    case (level)
      0:       return 4240;
      1:       return 4304;
      2:       return 4432;
      3:       return 4512;
      default: return 5504;
    endcase
  endfunction

  function automatic int iceil_ma(input int level);
    case (level)
      0:       return 1023;
      1:       return 2046;
      2:       return 3068;
      default: return 4092;
    endcase
  endfunction

  function automatic int istep_shift(input int level);
    case (level)
      0:       return 0;
      1:       return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/chg_therm_dec.sv
module chg_therm_dec #(
  parameter  int N  = 4,
  localparam int LW = $clog2(N + 1)
) (
  input  logic [N-1:0]  therm,
  output logic [LW-1:0] level,
  output logic          legal
);
  int ones;

  always_comb begin
    ones  = 0;
    legal = 1'b1;
    for (int k = 0; k < N; k++) begin
      if (therm[k]) ones = ones + 1;
    end
    for (int k = 1; k < N; k++) begin
      if (therm[k] && !therm[k-1]) legal = 1'b0;
    end
    level = legal ? LW'(ones) : '0;
  end
endmodule

// File: rtl/chg_vclamp.sv
module chg_vclamp
  import chg_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 3
) (
  input  logic [DW-1:0] req,
  input  logic [LW-1:0] level,
  output logic [DW-1:0] setpt,
  output logic          over
);
  localparam logic [DW-1:0] REF = DW'(VREF_MV);

  logic [DW-1:0] ceil_v;
  logic [DW-1:0] quant;
  logic [DW-1:0] chosen;

  always_comb begin
    ceil_v = DW'(vceil_mv(int'(level)));
    quant  = {req[DW-1:VSTEP_SHIFT], {VSTEP_SHIFT{1'b0}}};
    over   = (req > ceil_v);
    chosen = over ? ceil_v : quant;
    setpt  = (req < REF) ? '0 : (chosen - REF);
  end
endmodule

// File: rtl/chg_iclamp.sv
module chg_iclamp
  import chg_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 2
) (
  input  logic [DW-1:0] req,
  input  logic [LW-1:0] level,
  output logic [DW-1:0] setpt,
  output logic [DW-1:0] fullscale,
  output logic          over
);
  logic [DW-1:0] mask;

  always_comb begin
    fullscale = DW'(iceil_ma(int'(level)));
    mask      = {DW{1'b1}} << istep_shift(int'(level));
    over      = (req > fullscale);
    setpt     = over ? fullscale : (req & mask);
  end
endmodule

// File: rtl/chg_limit_clamp.sv
module chg_limit_clamp
  import chg_pkg::*;
#(
  parameter  int DW   = 16,
  parameter  int VT_W = 4,
  parameter  int IT_W = 3,
  localparam int VLW  = $clog2(VT_W + 1),
  localparam int ILW  = $clog2(IT_W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DW-1:0]   v_req,
  input  logic [DW-1:0]   i_req,
  input  logic [VT_W-1:0] v_sense,
  input  logic [IT_W-1:0] i_sense,
  output logic [DW-1:0]   v_set,
  output logic [DW-1:0]   i_set,
  output logic [DW-1:0]   i_fullscale,
  output logic            v_over,
  output logic            i_over
);
  logic [VLW-1:0] v_level;
  logic [ILW-1:0] i_level;
  logic           v_legal, i_legal;
  logic [DW-1:0]  v_set_c, i_set_c, i_fs_c;
  logic           v_over_c, i_over_c;

  chg_therm_dec #(.N(VT_W)) u_vdec (.therm(v_sense), .level(v_level), .legal(v_legal));
  chg_therm_dec #(.N(IT_W)) u_idec (.therm(i_sense), .level(i_level), .legal(i_legal));

  chg_vclamp #(.DW(DW), .LW(VLW)) u_vclamp (
    .req(v_req), .level(v_level), .setpt(v_set_c), .over(v_over_c)
  );

  chg_iclamp #(.DW(DW), .LW(ILW)) u_iclamp (
    .req(i_req), .level(i_level), .setpt(i_set_c), .fullscale(i_fs_c), .over(i_over_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_set       <= '0;
      i_set       <= '0;
      i_fullscale <= '0;
      v_over      <= 1'b0;
      i_over      <= 1'b0;
    end else if (load) begin
      v_set       <= v_set_c;
      i_set       <= i_set_c;
      i_fullscale <= i_fs_c;
      v_over      <= v_over_c;
      i_over      <= i_over_c;
    end
  end

  localparam logic [DW-1:0] REF_W   = DW'(VREF_MV);
  localparam logic [DW-1:0] VTOP_W  = DW'(vceil_mv(VT_W));
  localparam logic [DW-1:0] ILOW_W  = DW'(ICEIL_MIN);
  localparam logic [DW-1:0] I2046_W = DW'(2046);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(v_set) && $stable(i_set) && $stable(i_fullscale)
               && $stable(v_over) && $stable(i_over)));

  p_below_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && v_req < REF_W) |=> (v_set == '0 && !v_over));

  p_above_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && v_req > VTOP_W) |=> v_over);

  p_vstep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    v_set[VSTEP_SHIFT-1:0] == '0);

  p_iclamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    i_over |-> (i_set == i_fullscale));

  p_istep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (i_fullscale > I2046_W) |-> (i_set[1:0] == 2'b00));

  p_bad_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !i_legal) |=> (i_fullscale == ILOW_W));
endmodule

// File: tb/chg_limit_clamp_bench.sv
`timescale 1ns/1ps
module chg_limit_clamp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [15:0] v_req = '0, i_req = '0;
  logic [3:0]  v_sense = '0;
  logic [2:0]  i_sense = '0;
  logic [15:0] v_set, i_set, i_fullscale;
  logic        v_over, i_over;

  always #2 clk = ~clk;

  chg_limit_clamp u_chg_limit_clamp (
    .clk(clk), .rst_n(rst_n), .load(load), .v_req(v_req), .i_req(i_req),
    .v_sense(v_sense), .i_sense(i_sense), .v_set(v_set), .i_set(i_set),
    .i_fullscale(i_fullscale), .v_over(v_over), .i_over(i_over)
  );

  typedef struct {
    int vs; int is; int fs; bit vo; bit io;
  } exp_t;

  exp_t  sb_q[$];
  string tag_q[$];
  exp_t  last_exp;
  int    n_run = 0;
  int    n_fail = 0;

  task automatic check(input string req, input string what, input int act, input int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int tlevel(input int code, input int n);
    for (int k = 0; k <= n; k++) if (code == (1 << k) - 1) return k;
    return 0;
  endfunction

  function automatic exp_t model(input int vs_code, input int is_code, input int vr, input int ir);
    exp_t e;
    int vl, il, vc, ic, st;
    vl = tlevel(vs_code, 4);
    il = tlevel(is_code, 3);
    vc = (vl == 0) ? 4240 : (vl == 1) ? 4304 : (vl == 2) ? 4432 : (vl == 3) ? 4512 : 5504;
    ic = 1023 * (il + 1);
    if (il == 2) ic = 3068;
    st = (il == 0) ? 1 : (il == 1) ? 2 : 4;
    e.fs = ic;
    e.vo = (vr > vc);
    if (vr < 1104)  e.vs = 0;
    else if (e.vo)  e.vs = vc - 1104;
    else            e.vs = (vr / 16) * 16 - 1104;
    e.io = (ir > ic);
    e.is = e.io ? ic : (ir / st) * st;
    return e;
  endfunction

  task automatic send(input string tag, input int vs_code, input int is_code, input int vr, input int ir);
    @(negedge clk);
    v_sense = 4'(vs_code);
    i_sense = 3'(is_code);
    v_req   = 16'(vr);
    i_req   = 16'(ir);
    load    = 1'b1;
    last_exp = model(vs_code, is_code, vr, ir);
    sb_q.push_back(last_exp);
    tag_q.push_back(tag);
    @(negedge clk);
    load = 1'b0;
  endtask

  always @(posedge clk) begin
    if (rst_n && load) begin
      #1;
      if (sb_q.size() == 0) begin
        check("R10", "unexpected result", 1, 0);
      end else begin
        exp_t  e;
        string t;
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        check(t, "v_set", int'(v_set), e.vs);
        check(t, "v_over", int'(v_over), int'(e.vo));
        check(t, "i_set", int'(i_set), e.is);
        check(t, "i_over", int'(i_over), int'(e.io));
        check(t, "i_fullscale", int'(i_fullscale), e.fs);
      end
    end
  end

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "v_set in reset", int'(v_set), 0);
    check("R1", "i_fullscale in reset", int'(i_fullscale), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "i_set after reset", int'(i_set), 0);
    check("R1", "flags after reset", int'({v_over, i_over}), 0);

    send("R3_R6_lvl0", 4'b0000, 3'b000, 6000, 500);
    send("R3_R6_lvl1", 4'b0001, 3'b000, 6000, 500);
    send("R3_R6_lvl2", 4'b0011, 3'b000, 6000, 500);
    send("R3_R6_lvl3", 4'b0111, 3'b000, 6000, 500);
    send("R3_R6_lvl4", 4'b1111, 3'b000, 60000, 500);
    send("R2_R9_lvl0", 4'b1111, 3'b000, 5000, 5000);
    send("R2_R9_lvl1", 4'b1111, 3'b001, 5000, 5000);
    send("R2_R9_lvl2", 4'b1111, 3'b011, 5000, 5000);
    send("R2_R9_lvl3", 4'b1111, 3'b111, 5000, 5000);
    send("R5_step", 4'b0000, 3'b000, 4200, 777);
    send("R5_at_ceiling", 4'b0000, 3'b000, 4240, 1023);
    send("R6_one_above", 4'b0000, 3'b000, 4241, 1024);
    send("R6_within_step", 4'b0001, 3'b000, 4310, 0);
    send("R7_below_ref", 4'b1111, 3'b001, 1103, 1001);
    send("R7_zero", 4'b0011, 3'b011, 0, 3067);
    send("R7_at_ref", 4'b0111, 3'b111, 1104, 4092);
    send("R5_ref_step", 4'b0111, 3'b111, 1119, 4093);
    send("R5_first_step", 4'b1111, 3'b001, 1120, 2046);
    send("R8_gran2", 4'b1111, 3'b001, 3000, 2047);
    send("R8_gran4", 4'b1111, 3'b011, 3000, 3066);
    send("R4_vbad", 4'b0101, 3'b111, 6000, 4000);
    send("R4_ibad_a", 4'b1111, 3'b010, 5000, 2000);
    send("R4_ibad_b", 4'b1000, 3'b110, 4300, 999);
    send("R5_R8_mid", 4'b0011, 3'b001, 3333, 1234);

    @(negedge clk);
    v_sense = 4'b1111; i_sense = 3'b111; v_req = 16'd5000; i_req = 16'd3000;
    repeat (5) @(negedge clk);
    check("R10", "v_set held", int'(v_set), last_exp.vs);
    check("R10", "i_set held", int'(i_set), last_exp.is);
    check("R10", "i_fullscale held", int'(i_fullscale), last_exp.fs);
    check("R10", "flags held", int'({v_over, i_over}), int'({last_exp.vo, last_exp.io}));

    repeat (2) @(negedge clk);
    check("R10", "scoreboard drained", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule